// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the housekeeping register file of a processor core module. It sits on a simple 32-bit register bus. The bus carries a word index and separate read and write strobes. Read data comes back on the cycle after the strobe. The block holds:

- fixed identity and status words;
- two clock-generator words guarded by an unlock key;
- a control word that picks what appears at address zero and can request a system reset;
- two general-purpose flag words with separate set and clear addresses;
- a free-running reference counter;
- a read-only window into a memory-description byte table;
- a small interrupt mask section.

The interrupt section keeps the raw interrupt state, which is a single software-driven level on bit 0. It drives two registered request lines: a normal one (IRQ) and a fast one (FIQ). Each line has its own enable mask. The integrating system uses two more outputs: `flash_at_zero_o`, which routes boot flash to address zero, and `rst_req_o`, a reset-request pulse. An access to an index the block does not decode returns zero, changes no state and raises a one-cycle error flag.

Top module: `cm_sysctrl`

## Requirements
- R1: A read of index 0 returns 0x411A3001, index 1 returns 0, index 4 returns 0x00100000, and indices 32 to 35 return 0. Writes to 32 to 35 change nothing and do not raise the error flag. Read data appears on `rdata_o` one cycle after `rd_en_i` and is zero in every other cycle.
- R2: A write to index 5 stores wdata[15:0] as the lock value. A read of index 5 returns 0x0001A05F while the stored value is 0xA05F, and otherwise returns the stored value zero-extended.
- R3: Writes to index 2 (main oscillator) and index 7 (auxiliary oscillator) store the full word only while the lock value is 0xA05F. Otherwise they are dropped. Both indices read back their stored word.
- R4: A write to index 3 keeps wdata bits 0 and 2 and discards the other bits. Bit 3 of a write produces a one-cycle `rst_req_o` pulse in the cycle after the write. A read of index 3 shows only bits 0 and 2, so bit 3 always reads as zero.
- R5: `flash_at_zero_o` is high while control bit 2 is 0 and low while it is 1. It follows the register in the same cycle that the register changes.
- R6: A write to index 12 ORs wdata into the flags word. A write to index 13 clears the flag bits that are written as 1. Index 12 reads the flags word. Indices 14 and 15 work the same way on a second (non-volatile) flags word, which is read at index 14. Both flags words reset to 0.
- R7: Index 10 reads a 32-bit counter. The counter is zero at reset, advances by one on each cycle where `ref_tick_i` is high, and wraps.
- R8: Reset values are as follows. Oscillator: 0x01000048. Auxiliary oscillator: 0x0007FEFF. Init word (index 9): 0x00000112. Memory-timing word (index 8): 0x00011122 ORed with a size code taken from MEM_MB:
  - 0x10 for 256 MB or more;
  - 0x0C for 128 MB or more;
  - 0x08 for 64 MB or more;
  - 0x04 for 32 MB or more;
  - 0 below 32 MB.
  Indices 8 and 9 accept any write. The default MEM_MB of 128 gives a reset value of 0x0001112E.
- R9: Reads of indices 64 to 95 return, in bits 7:0, entry `index` of a 128-byte table. That table holds the ASCII text "MODULE-DRAM" at entries 73 to 83 and zero everywhere else. Reads of indices 96 to 127 return 0.
- R10: A write to index 18 ORs wdata into the IRQ enable mask, and a write to index 19 clears the enable bits written as 1. Index 16 reads raw AND IRQ enable, index 17 reads raw, and index 18 reads the enable mask. Indices 24 to 27 do the same for the FIQ mask.
- R11: The raw interrupt word has only bit 0, the software level. A write with wdata[0]=1 to index 20 sets it, and a write with wdata[0]=1 to index 21 clears it. A read of index 20 returns the level in bit 0.
- R12: `irq_o` equals the OR of (raw AND IRQ enable) as it stood before the previous clock edge, which is one cycle behind the registers. `fiq_o` does the same with the FIQ enable.
- R13: A read of an index not listed above for reading raises `err_o` for one cycle and returns 0. The indices readable without error are 0–5, 7–10, 12, 14, 16–18, 20, 24–26, 32–35 and 64–127; index 6 is among those that are not. A write to an index not listed for writing raises `err_o` for one cycle and changes nothing. The indices writable without error are 2, 3, 5, 7–9, 12–15, 18–21, 26, 27 and 32–35. A cycle with both strobes raises the flag if either access is undecoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_addr_i | input | 7 | Word index (byte offset >> 2) |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| ref_tick_i | input | 1 | One-cycle reference-rate tick for the counter |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| err_o | output | 1 | One-cycle undecoded-access flag |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| flash_at_zero_o | output | 1 | High when boot flash is mapped at address zero |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Results arrive at three different times.

- `rdata_o`, `err_o` and `rst_req_o` come from the edge that samples the strobe, so they are due one cycle after the access.
- `flash_at_zero_o` follows the control register directly, so it changes at the same edge as the write.
- `irq_o` and `fiq_o` lag the enable and level registers by one more edge, so they are due two edges after the write that changes them.

The bench drives inputs on the falling edge. A behavioural model advances on every rising edge and predicts each output with exactly these lags. All outputs are compared on the following falling edge, so every prediction is checked in the cycle it is due.

// File: rtl/cm_sysctrl_pkg.sv
package cm_sysctrl_pkg;
  localparam int IDX_W = 7;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t I_ID       = 7'd0;
  localparam idx_t I_PROC     = 7'd1;
  localparam idx_t I_OSC      = 7'd2;
  localparam idx_t I_CTRL     = 7'd3;
  localparam idx_t I_STAT     = 7'd4;
  localparam idx_t I_LOCK     = 7'd5;
  localparam idx_t I_AUXOSC   = 7'd7;
  localparam idx_t I_SDRAM    = 7'd8;
  localparam idx_t I_INIT     = 7'd9;
  localparam idx_t I_REFCNT   = 7'd10;
  localparam idx_t I_FLAG_SET = 7'd12;
  localparam idx_t I_FLAG_CLR = 7'd13;
  localparam idx_t I_NVF_SET  = 7'd14;
  localparam idx_t I_NVF_CLR  = 7'd15;
  localparam idx_t I_IRQ_STAT = 7'd16;
  localparam idx_t I_IRQ_RAW  = 7'd17;
  localparam idx_t I_IRQ_ENS  = 7'd18;
  localparam idx_t I_IRQ_ENC  = 7'd19;
  localparam idx_t I_SW_SET   = 7'd20;
  localparam idx_t I_SW_CLR   = 7'd21;
  localparam idx_t I_FIQ_STAT = 7'd24;
  localparam idx_t I_FIQ_RAW  = 7'd25;
  localparam idx_t I_FIQ_ENS  = 7'd26;
  localparam idx_t I_FIQ_ENC  = 7'd27;
  localparam idx_t I_VOLT_LO  = 7'd32;
  localparam idx_t I_VOLT_HI  = 7'd35;
  localparam idx_t I_WIN_LO   = 7'd64;

  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] LOCK_OPEN_RD = 32'h0001_A05F;

  localparam int LANE_IRQ = 0;
  localparam int LANE_FIQ = 1;
  localparam int LANES    = 2;

  function automatic logic [31:0] size_code(int mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else               return 32'h00;
  endfunction
endpackage

// File: rtl/cm_refcnt.sv
module cm_refcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cm_irq_mask.sv
module cm_irq_mask #(
  parameter int W     = 32,
  parameter int LANES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          set_i,
  input  logic [LANES-1:0]          clr_i,
  input  logic [W-1:0]              wdata_i,
  input  logic [W-1:0]              raw_i,
  output logic [LANES-1:0][W-1:0]   en_o,
  output logic [LANES-1:0]          req_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] en_q;
    logic         req_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= '0;
        req_q <= 1'b0;
      end else begin
        if (set_i[g])      en_q <= en_q | wdata_i;
        else if (clr_i[g]) en_q <= en_q & ~wdata_i;
        req_q <= |(raw_i & en_q);
      end
    end

    assign en_o[g]  = en_q;
    assign req_o[g] = req_q;
  end
endmodule

// File: rtl/cm_desc_rom.sv
module cm_desc_rom #(
  parameter int                     IDX_W   = 7,
  parameter int                     LIMIT   = 96,
  parameter int                     STR_POS = 73,
  parameter int                     STR_LEN = 11,
  parameter logic [8*STR_LEN-1:0]   STR     = "MODULE-DRAM"
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  int unsigned pos;

  always_comb begin
    pos    = int'(idx_i);
    byte_o = 8'h00;
    if (pos < LIMIT && pos >= STR_POS && pos < STR_POS + STR_LEN)
      byte_o = STR[8*(STR_LEN-1-(pos-STR_POS)) +: 8];
  end
endmodule

// File: rtl/cm_sysctrl.sv
module cm_sysctrl
  import cm_sysctrl_pkg::*;
#(
  parameter int MEM_MB = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] word_addr_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wdata_i,
  input  logic             ref_tick_i,
  output logic [31:0]      rdata_o,
  output logic             err_o,
  output logic             irq_o,
  output logic             fiq_o,
  output logic             flash_at_zero_o,
  output logic             rst_req_o
);
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);
  localparam int          WIN_END   = 96;

  logic [31:0] osc_q, aux_q, sdram_q, init_q, flag_q, nvf_q;
  logic [15:0] lock_q;
  logic        led_q, remap_q, sw_lvl_q;
  logic [31:0] refcnt, raw;
  logic [LANES-1:0][31:0] en_q;
  logic [LANES-1:0]       req;
  logic [LANES-1:0]       en_set, en_clr;
  logic [7:0]  rom_byte;
  logic        unlocked;
  logic        rd_ok, wr_ok;
  logic [31:0] rd_val;

  idx_t a;
  assign a        = word_addr_i;
  assign unlocked = (lock_q == UNLOCK_KEY);
  assign raw      = {31'b0, sw_lvl_q};

  cm_refcnt #(.W(32)) i_refcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(ref_tick_i),
    .cnt_o (refcnt)
  );

  assign en_set[LANE_IRQ] = wr_en_i && a == I_IRQ_ENS;
  assign en_clr[LANE_IRQ] = wr_en_i && a == I_IRQ_ENC;
  assign en_set[LANE_FIQ] = wr_en_i && a == I_FIQ_ENS;
  assign en_clr[LANE_FIQ] = wr_en_i && a == I_FIQ_ENC;

  cm_irq_mask #(.W(32), .LANES(LANES)) i_irq_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .wdata_i(wdata_i),
    .raw_i  (raw),
    .en_o   (en_q),
    .req_o  (req)
  );

  assign irq_o = req[LANE_IRQ];
  assign fiq_o = req[LANE_FIQ];

  cm_desc_rom #(.IDX_W(IDX_W), .LIMIT(WIN_END)) i_desc_rom (
    .idx_i (a),
    .byte_o(rom_byte)
  );

  // read decode
  always_comb begin
    rd_ok  = 1'b1;
    rd_val = '0;
    if (a >= I_WIN_LO) begin
      rd_val = {24'b0, rom_byte};
    end else begin
      case (a) inside
        I_ID:               rd_val = ID_WORD;
        I_PROC:             rd_val = '0;
        I_OSC:              rd_val = osc_q;
        I_CTRL:             rd_val = {29'b0, remap_q, 1'b0, led_q};
        I_STAT:             rd_val = STAT_WORD;
        I_LOCK:             rd_val = unlocked ? LOCK_OPEN_RD : {16'b0, lock_q};
        I_AUXOSC:           rd_val = aux_q;
        I_SDRAM:            rd_val = sdram_q;
        I_INIT:             rd_val = init_q;
        I_REFCNT:           rd_val = refcnt;
        I_FLAG_SET:         rd_val = flag_q;
        I_NVF_SET:          rd_val = nvf_q;
        I_IRQ_STAT:         rd_val = raw & en_q[LANE_IRQ];
        I_IRQ_RAW:          rd_val = raw;
        I_IRQ_ENS:          rd_val = en_q[LANE_IRQ];
        I_SW_SET:           rd_val = {31'b0, raw[0]};
        I_FIQ_STAT:         rd_val = raw & en_q[LANE_FIQ];
        I_FIQ_RAW:          rd_val = raw;
        I_FIQ_ENS:          rd_val = en_q[LANE_FIQ];
        [I_VOLT_LO:I_VOLT_HI]: rd_val = '0;
        default:            rd_ok  = 1'b0;
      endcase
    end
  end

  // write decode
  always_comb begin
    case (a) inside
      I_OSC, I_CTRL, I_LOCK, I_AUXOSC, I_SDRAM, I_INIT,
      I_FLAG_SET, I_FLAG_CLR, I_NVF_SET, I_NVF_CLR,
      I_IRQ_ENS, I_IRQ_ENC, I_SW_SET, I_SW_CLR,
      I_FIQ_ENS, I_FIQ_ENC, [I_VOLT_LO:I_VOLT_HI]: wr_ok = 1'b1;
      default:                                     wr_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q    <= OSC_RST;
      aux_q    <= AUX_RST;
      sdram_q  <= SDRAM_RST;
      init_q   <= INIT_RST;
      flag_q   <= '0;
      nvf_q    <= '0;
      lock_q   <= '0;
      led_q    <= 1'b0;
      remap_q  <= 1'b0;
      sw_lvl_q <= 1'b0;
    end else if (wr_en_i) begin
      case (a)
        I_OSC:      if (unlocked) osc_q <= wdata_i;
        I_AUXOSC:   if (unlocked) aux_q <= wdata_i;
        I_CTRL: begin
          led_q   <= wdata_i[0];
          remap_q <= wdata_i[2];
        end
        I_LOCK:     lock_q  <= wdata_i[15:0];
        I_SDRAM:    sdram_q <= wdata_i;
        I_INIT:     init_q  <= wdata_i;
        I_FLAG_SET: flag_q  <= flag_q | wdata_i;
        I_FLAG_CLR: flag_q  <= flag_q & ~wdata_i;
        I_NVF_SET:  nvf_q   <= nvf_q | wdata_i;
        I_NVF_CLR:  nvf_q   <= nvf_q & ~wdata_i;
        I_SW_SET:   if (wdata_i[0]) sw_lvl_q <= 1'b1;
        I_SW_CLR:   if (wdata_i[0]) sw_lvl_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      err_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rdata_o   <= rd_en_i ? rd_val : '0;
      err_o     <= (rd_en_i && !rd_ok) || (wr_en_i && !wr_ok);
      rst_req_o <= wr_en_i && a == I_CTRL && wdata_i[3];
    end
  end

  assign flash_at_zero_o = !remap_q;
endmodule

// File: rtl/cm_sysctrl_chk.sv
module cm_sysctrl_chk
  import cm_sysctrl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input idx_t        word_addr_i,
  input logic        rd_en_i,
  input logic        wr_en_i,
  input logic [31:0] wdata_i,
  input logic        ref_tick_i,
  input logic        err_o,
  input logic        irq_o,
  input logic        fiq_o,
  input logic        flash_at_zero_o,
  input logic        rst_req_o,
  input logic [31:0] refcnt,
  input logic [31:0] osc_q,
  input logic [15:0] lock_q,
  input logic        sw_lvl_q,
  input logic        irq_en0,
  input logic        fiq_en0
);
  a_r4_rst_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_en_i && word_addr_i == I_CTRL && wdata_i[3]));

  a_r5_remap_only_on_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flash_at_zero_o) |-> $past(wr_en_i && word_addr_i == I_CTRL));

  a_r3_osc_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_addr_i == I_OSC && lock_q != UNLOCK_KEY) |=> $stable(osc_q));

  a_r7_tick_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_i |=> refcnt == 32'($past(refcnt) + 32'd1));

  a_r7_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> $stable(refcnt));

  a_r11_soft_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_addr_i == I_SW_SET && wdata_i[0]) |=> sw_lvl_q);

  a_r12_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(sw_lvl_q & irq_en0));

  a_r12_fiq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(sw_lvl_q & fiq_en0));

  a_r13_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_en_i || wr_en_i));
endmodule

bind cm_sysctrl cm_sysctrl_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .word_addr_i    (word_addr_i),
  .rd_en_i        (rd_en_i),
  .wr_en_i        (wr_en_i),
  .wdata_i        (wdata_i),
  .ref_tick_i     (ref_tick_i),
  .err_o          (err_o),
  .irq_o          (irq_o),
  .fiq_o          (fiq_o),
  .flash_at_zero_o(flash_at_zero_o),
  .rst_req_o      (rst_req_o),
  .refcnt         (refcnt),
  .osc_q          (osc_q),
  .lock_q         (lock_q),
  .sw_lvl_q       (sw_lvl_q),
  .irq_en0        (en_q[0][0]),
  .fiq_en0        (en_q[1][0])
);

// File: tb/test_cm_sysctrl.sv
`timescale 1ns/1ps
module test_cm_sysctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [6:0]  word_addr_i = '0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        ref_tick_i = 1'b0;
  logic [31:0] rdata_o;
  logic        err_o, irq_o, fiq_o, flash_at_zero_o, rst_req_o;

  always #4 clk_i = ~clk_i;

  cm_sysctrl #(.MEM_MB(128)) i_cm_sysctrl (.*);

  // reference model state
  int unsigned m_osc, m_aux, m_sdram, m_init, m_flag, m_nvf, m_lock, m_ctrl, m_cnt;
  int unsigned m_ien, m_fen, m_lvl;
  int unsigned e_rdata;
  bit e_err, e_irq, e_fiq, e_flash, e_rst;
  bit cmp_on = 0;
  bit tick_rand = 0;
  int unsigned last_rd_idx = 0;
  int n_cmp = 0, n_bad = 0;
  string part = "MODULE-DRAM";

  function automatic bit can_read(int i);
    if (i >= 64) return 1;
    return (i <= 5) || (i >= 7 && i <= 10) || i == 12 || i == 14 ||
           (i >= 16 && i <= 18) || i == 20 || (i >= 24 && i <= 26) ||
           (i >= 32 && i <= 35);
  endfunction

  function automatic bit can_write(int i);
    return i == 2 || i == 3 || i == 5 || (i >= 7 && i <= 9) || (i >= 12 && i <= 15) ||
           (i >= 18 && i <= 21) || i == 26 || i == 27 || (i >= 32 && i <= 35);
  endfunction

  function automatic int unsigned model_read(int i);
    if (!can_read(i)) return 0;
    if (i >= 96) return 0;
    if (i >= 64) return (i >= 73 && i < 84) ? int'(part[i-73]) : 0;
    case (i)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return m_ctrl;
      4: return 32'h00100000;
      5: return (m_lock == 32'hA05F) ? 32'h1A05F : m_lock;
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      10: return m_cnt;
      12: return m_flag;
      14: return m_nvf;
      16: return m_lvl & m_ien;
      17, 25: return m_lvl;
      18: return m_ien;
      20: return m_lvl & 1;
      24: return m_lvl & m_fen;
      26: return m_fen;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (i >= 64) return "R9";
    case (i)
      0, 1, 4, 32, 33, 34, 35: return "R1";
      5: return "R2";
      2, 7: return "R3/R8";
      3: return "R4";
      8, 9: return "R8";
      10: return "R7";
      12, 14: return "R6";
      16, 17, 18, 24, 25, 26: return "R10";
      20: return "R11";
      default: return "R13";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_init = 32'h112;
      m_sdram = 32'h00011122 | 32'h0C;
      m_flag = 0; m_nvf = 0; m_lock = 0; m_ctrl = 0; m_cnt = 0;
      m_ien = 0; m_fen = 0; m_lvl = 0;
      e_rdata = 0; e_err = 0; e_irq = 0; e_fiq = 0; e_rst = 0; e_flash = 1;
    end else begin
      int i;
      int unsigned d;
      i = int'(word_addr_i);
      d = wdata_i;
      e_rdata = rd_en_i ? model_read(i) : 0;
      if (rd_en_i) last_rd_idx = i;
      e_err = (rd_en_i && !can_read(i)) || (wr_en_i && !can_write(i));
      e_rst = wr_en_i && i == 3 && d[3];
      e_irq = (m_lvl & m_ien) != 0;
      e_fiq = (m_lvl & m_fen) != 0;
      if (ref_tick_i) m_cnt = m_cnt + 1;
      if (wr_en_i) begin
        case (i)
          2: if (m_lock == 32'hA05F) m_osc = d;
          7: if (m_lock == 32'hA05F) m_aux = d;
          3: m_ctrl = d & 5;
          5: m_lock = d & 32'hFFFF;
          8: m_sdram = d;
          9: m_init = d;
          12: m_flag = m_flag | d;
          13: m_flag = m_flag & ~d;
          14: m_nvf = m_nvf | d;
          15: m_nvf = m_nvf & ~d;
          18: m_ien = m_ien | d;
          19: m_ien = m_ien & ~d;
          26: m_fen = m_fen | d;
          27: m_fen = m_fen & ~d;
          20: if (d[0]) m_lvl = 1;
          21: if (d[0]) m_lvl = 0;
          default: ;
        endcase
      end
      e_flash = (m_ctrl & 4) == 0;
    end
  end

  task automatic chk(string req, int unsigned act, int unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on) begin
      chk({tag_of(int'(last_rd_idx)), " rdata"}, rdata_o, e_rdata);
      chk("R13 err", {31'b0, err_o}, {31'b0, e_err});
      chk("R12 irq", {31'b0, irq_o}, {31'b0, e_irq});
      chk("R12 fiq", {31'b0, fiq_o}, {31'b0, e_fiq});
      chk("R5 flash_at_zero", {31'b0, flash_at_zero_o}, {31'b0, e_flash});
      chk("R4 rst_req", {31'b0, rst_req_o}, {31'b0, e_rst});
    end
    ref_tick_i <= tick_rand ? ($urandom_range(0, 2) == 0) : 1'b0;
  end

  task automatic acc(bit r, bit w, int i, int unsigned d);
    @(negedge clk_i);
    rd_en_i = r; wr_en_i = w; word_addr_i = 7'(i); wdata_i = d;
  endtask
  task automatic rd(int i);                  acc(1, 0, i, 0); endtask
  task automatic wr(int i, int unsigned d);  acc(0, 1, i, d); endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) acc(0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    cmp_on = 1;  // R8 reset state compared while in reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    // R1 R8 R9 R13: sweep every index after reset
    for (int i = 0; i < 128; i++) rd(i);
    // R3 locked drop, R2 unlock
    wr(2, 32'hDEADBEEF); wr(7, 32'h12345678); rd(2); rd(7);
    wr(5, 32'h7777A05F); rd(5);
    wr(2, 32'hDEADBEEF); wr(7, 32'h12345678); rd(2); rd(7);
    wr(5, 32'h0000A05E); rd(5); wr(2, 32'h0); rd(2);
    // R4 R5 control
    wr(3, 32'hFFFF_FFFF); rd(3); idle(1);
    wr(3, 32'h8); rd(3); wr(3, 32'h4); idle(2); wr(3, 32'h1); rd(3);
    // R6 flags
    wr(12, 32'hF0F0); wr(13, 32'h00F0); rd(12); wr(14, 32'hA5); wr(15, 32'h5); rd(14); rd(12);
    // R8 writable words
    wr(8, 32'hCAFE0001); wr(9, 32'h0BADF00D); rd(8); rd(9);
    // R7 counter
    tick_rand = 1;
    for (int k = 0; k < 40; k++) rd(10);
    tick_rand = 0; rd(10);
    // R10 R11 R12 interrupts
    wr(20, 1); rd(20); rd(17); idle(2);
    wr(18, 32'h1); idle(2); rd(16);
    wr(26, 32'h3); idle(2); rd(24); rd(26);
    wr(19, 32'h1); idle(2); wr(21, 32'h0); rd(20); wr(21, 32'h1); idle(2);
    wr(20, 32'h2); rd(20); wr(27, 32'hFFFFFFFF); rd(26); idle(2);
    // R1 R13 ignored writes
    wr(32, 32'hFFFF); wr(35, 1); wr(0, 5); wr(6, 1); wr(40, 3); wr(70, 9); rd(6); rd(13);
    acc(1, 1, 20, 1); acc(1, 1, 5, 32'hA05F); acc(1, 1, 4, 0);
    for (int i = 0; i < 40; i++) rd(i);
    // random mix
    tick_rand = 1;
    for (int k = 0; k < 600; k++) begin
      int i;
      int unsigned d;
      i = ($urandom_range(0, 5) == 0) ? int'($urandom_range(60, 127)) : int'($urandom_range(0, 40));
      d = $urandom();
      if (i == 5 && d[0]) d = 32'hA05F;
      acc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), i, d);
    end
    tick_rand = 0;
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule